// File: doc/BRIEF.md
# Core-to-Memory Bus Bridge with Boot Overlay Control

This block sits between an 8-bit processor core and the memory bus outside it. From the core it takes a 16-bit address, active-high read and write strobes, and a separate memory-request qualifier. It returns two region flags to the core: one for the top two address pages and one for the boot page while the boot overlay is still mapped. It also produces a chip-select qualifier, the pad drive enable with the outgoing write data, and the read data that it takes from the pads. The read path is transparent while a qualified read is under way and holds the last value it sampled once the read ends.

A single one-shot register decides whether the boot overlay is mapped. It starts mapped after reset. A qualified write of any non-zero byte to address 0xFF50 unmaps the overlay, and only a reset maps it again. The chip-select qualifier follows the memory request alone, so a request with neither strobe high still selects. A request with both strobes high counts as a clash: it neither drives the pads nor updates the read hold.

Top module: `cpu_bus_bridge`

## Requirements
- R1: `hi_page` is 1 exactly when address bits [15:8] equal 0xFE or 0xFF, whatever the strobes and the request are doing.
- R2: `boot_region` is 1 exactly when address bits [15:8] equal 0x00 and the boot overlay is mapped. The overlay is mapped after reset.
- R3: A qualified write (request=1, write=1, read=0) to 0xFF50 with non-zero data unmaps the overlay from the next rising clock edge until reset. A qualified write of 0x00 to that address leaves the overlay mapped.
- R4: A write to 0xFF50 with the request low does not change the overlay state, and neither does a write to that address with both strobes high.
- R5: While reset is released, `chip_sel` equals the memory request, including when neither strobe is high.
- R6: `pad_oe` is 1 only during a qualified write. While it is 1, `pad_dout` equals `core_wdata`. Otherwise `pad_dout` is 0x00.
- R7: During a qualified read (request=1, read=1, write=0), `core_rdata` follows `pad_din` in the same cycle, and every rising edge of such a read stores `pad_din`. Outside a qualified read, `core_rdata` shows the stored value.
- R8: While `rst_n` is low, `chip_sel` and `pad_oe` are 0, `core_rdata` is 0x00 and the overlay is mapped again. After release, the stored read value is 0x00.
- R9: A request with both strobes high asserts `chip_sel`, does not set `pad_oe`, and does not change the stored read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_addr | input | 16 | Address from the core |
| core_rd | input | 1 | Read strobe, active high |
| core_wr | input | 1 | Write strobe, active high |
| core_mreq | input | 1 | Memory-request qualifier, active high |
| core_wdata | input | 8 | Write data from the core |
| pad_din | input | 8 | Data arriving from the pads |
| hi_page | output | 1 | Address is in page 0xFE or 0xFF |
| boot_region | output | 1 | Address is in page 0x00 and the overlay is mapped |
| chip_sel | output | 1 | Qualified chip-select enable |
| pad_oe | output | 1 | Pad drive enable |
| pad_dout | output | 8 | Data driven to the pads |
| core_rdata | output | 8 | Read data returned to the core |

## Verification
The overlay state has no output of its own. It shows only through `boot_region` while the address is on page 0x00, so every write to 0xFF50 that must be ignored (zero data, request low, both strobes high) is followed at once by a page-zero probe that proves the overlay is still mapped. The stored read value is proven the same way: idle cycles after each read, and cycles with both strobes high, have to return the last sampled byte even though the pad input has changed since.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam int BB_ADDR_W = 16;
    localparam int BB_DATA_W = 8;
    localparam int BB_PAGE_W = BB_ADDR_W - 8;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_CLASH = 2'd3
    } cyc_e;

    typedef struct packed {
        logic overlay_off;
    } ovl_state_t;

    typedef struct packed {
        logic [BB_DATA_W-1:0] held;
    } hold_state_t;
endpackage

// File: rtl/bb_cycle_classify.sv
module bb_cycle_classify
    import bb_pkg::*;
(
    input  logic rst_n,
    input  logic mreq,
    input  logic rd,
    input  logic wr,
    output cyc_e cyc
);
    always_comb begin
        cyc = CYC_IDLE;
        if (rst_n && mreq) begin
            unique case ({rd, wr})
                2'b10:   cyc = CYC_READ;
                2'b01:   cyc = CYC_WRITE;
                2'b11:   cyc = CYC_CLASH;
                default: cyc = CYC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bb_region_decode.sv
module bb_region_decode
    import bb_pkg::*;
#(
    parameter int                 NUM_HI   = 2,
    parameter logic [BB_PAGE_W-1:0] HI_BASE  = 8'hFE,
    parameter logic [BB_PAGE_W-1:0] BOOT_PG  = 8'h00
) (
    input  logic [BB_PAGE_W-1:0] page,
    input  logic                 overlay_on,
    output logic                 hi_page,
    output logic                 boot_region
);
    logic [NUM_HI-1:0] hit;

    for (genvar g = 0; g < NUM_HI; g++) begin : g_hi
        localparam logic [BB_PAGE_W-1:0] PG = HI_BASE + BB_PAGE_W'(g);
        assign hit[g] = (page == PG);
    end

    assign hi_page     = |hit;
    assign boot_region = overlay_on && (page == BOOT_PG);
endmodule

// File: rtl/bb_overlay_reg.sv
module bb_overlay_reg
    import bb_pkg::*;
#(
    parameter logic [BB_ADDR_W-1:0] REG_ADDR = 16'hFF50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cyc_e                 cyc,
    input  logic [BB_ADDR_W-1:0] addr,
    input  logic [BB_DATA_W-1:0] wdata,
    output logic                 overlay_on
);
    ovl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cyc == CYC_WRITE && addr == REG_ADDR && wdata != '0) begin
            st_d.overlay_off = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overlay_on = !st_q.overlay_off;
endmodule

// File: rtl/bb_read_hold.sv
module bb_read_hold
    import bb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  cyc_e                 cyc,
    input  logic [BB_DATA_W-1:0] pad_din,
    output logic [BB_DATA_W-1:0] rdata
);
    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cyc == CYC_READ) st_d.held = pad_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = (cyc == CYC_READ) ? pad_din : st_q.held;
endmodule

// File: rtl/cpu_bus_bridge.sv
module cpu_bus_bridge
    import bb_pkg::*;
#(
    parameter logic [BB_ADDR_W-1:0] OVL_REG_ADDR = 16'hFF50,
    parameter logic [BB_PAGE_W-1:0] HI_BASE_PG   = 8'hFE,
    parameter int                   HI_PAGES     = 2,
    parameter logic [BB_PAGE_W-1:0] BOOT_PAGE    = 8'h00
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BB_ADDR_W-1:0] core_addr,
    input  logic                 core_rd,
    input  logic                 core_wr,
    input  logic                 core_mreq,
    input  logic [BB_DATA_W-1:0] core_wdata,
    input  logic [BB_DATA_W-1:0] pad_din,
    output logic                 hi_page,
    output logic                 boot_region,
    output logic                 chip_sel,
    output logic                 pad_oe,
    output logic [BB_DATA_W-1:0] pad_dout,
    output logic [BB_DATA_W-1:0] core_rdata
);
    cyc_e cyc;
    logic overlay_on;

    bb_cycle_classify u_cls (
        .rst_n (rst_n),
        .mreq  (core_mreq),
        .rd    (core_rd),
        .wr    (core_wr),
        .cyc   (cyc)
    );

    bb_region_decode #(
        .NUM_HI  (HI_PAGES),
        .HI_BASE (HI_BASE_PG),
        .BOOT_PG (BOOT_PAGE)
    ) u_dec (
        .page        (core_addr[BB_ADDR_W-1 -: BB_PAGE_W]),
        .overlay_on  (overlay_on),
        .hi_page     (hi_page),
        .boot_region (boot_region)
    );

    bb_overlay_reg #(
        .REG_ADDR (OVL_REG_ADDR)
    ) u_ovl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc        (cyc),
        .addr       (core_addr),
        .wdata      (core_wdata),
        .overlay_on (overlay_on)
    );

    bb_read_hold u_rdh (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc     (cyc),
        .pad_din (pad_din),
        .rdata   (core_rdata)
    );

    assign chip_sel = rst_n && core_mreq;
    assign pad_oe   = (cyc == CYC_WRITE);
    assign pad_dout = pad_oe ? core_wdata : '0;
endmodule

// File: rtl/cpu_bus_bridge_chk.sv
module cpu_bus_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] core_addr,
    input logic        core_rd,
    input logic        core_wr,
    input logic        core_mreq,
    input logic        hi_page,
    input logic        boot_region,
    input logic        chip_sel,
    input logic        pad_oe,
    input logic [7:0]  pad_dout,
    input logic [7:0]  core_rdata
);
    logic pg_zero, rd_ok;
    assign pg_zero = (core_addr[15:8] == 8'h00);
    assign rd_ok   = rst_n && core_mreq && core_rd && !core_wr;

    p_hi_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hi_page == (core_addr[15:8] == 8'hFE || core_addr[15:8] == 8'hFF));

    p_boot_page_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        boot_region |-> pg_zero);

    p_overlay_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_zero && !boot_region) |=> !(pg_zero && boot_region));

    p_cs_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel == core_mreq);

    p_oe_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> (core_mreq && core_wr && !core_rd));

    p_dout_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe |-> (pad_dout == 8'h00));

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ok && $past(!rd_ok)) |-> $stable(core_rdata));

    p_clash_no_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_mreq && core_rd && core_wr) |-> (!pad_oe && chip_sel));
endmodule

bind cpu_bus_bridge cpu_bus_bridge_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_addr   (core_addr),
    .core_rd     (core_rd),
    .core_wr     (core_wr),
    .core_mreq   (core_mreq),
    .hi_page     (hi_page),
    .boot_region (boot_region),
    .chip_sel    (chip_sel),
    .pad_oe      (pad_oe),
    .pad_dout    (pad_dout),
    .core_rdata  (core_rdata)
);

// File: tb/cpu_bus_bridge_bench.sv
module cpu_bus_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] core_addr = '0;
    logic        core_rd = 1'b0, core_wr = 1'b0, core_mreq = 1'b0;
    logic [7:0]  core_wdata = '0, pad_din = '0;
    logic        hi_page, boot_region, chip_sel, pad_oe;
    logic [7:0]  pad_dout, core_rdata;

    always #5 clk = ~clk;

    cpu_bus_bridge u_cpu_bus_bridge (.*);

    typedef struct {
        logic       hi, boot, cs, oe;
        logic [7:0] dout, rdata;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;

    logic       m_ovl_on = 1'b1;
    logic [7:0] m_held = 8'h00;

    task automatic apply(input logic r, input logic [15:0] a, input logic rd,
                         input logic wr, input logic mq, input logic [7:0] wd,
                         input logic [7:0] pd, input string tag);
        exp_t e;
        logic qrd, qwr;
        @(negedge clk);
        rst_n = r; core_addr = a; core_rd = rd; core_wr = wr;
        core_mreq = mq; core_wdata = wd; pad_din = pd;
        if (!r) begin m_ovl_on = 1'b1; m_held = 8'h00; end
        qrd = r && mq && rd && !wr;
        qwr = r && mq && wr && !rd;
        e.hi    = (a[15:8] == 8'hFE) || (a[15:8] == 8'hFF);
        e.boot  = (a[15:8] == 8'h00) && m_ovl_on;
        e.cs    = r && mq;
        e.oe    = qwr;
        e.dout  = qwr ? wd : 8'h00;
        e.rdata = qrd ? pd : m_held;
        e.tag   = tag;
        exp_q.push_back(e);
        ->chk_ev;
        #2;
        if (qwr && a == 16'hFF50 && wd != 8'h00) m_ovl_on = 1'b0;
        if (qrd) m_held = pd;
    endtask

    task automatic cmp(input string tag, input string f, input int act, input int ex);
        if (act != ex) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, f, act, ex);
        end
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(chk_ev);
            #1;
            e = exp_q.pop_front();
            n_chk++;
            cmp(e.tag, "hi_page",     int'(hi_page),     int'(e.hi));
            cmp(e.tag, "boot_region", int'(boot_region), int'(e.boot));
            cmp(e.tag, "chip_sel",    int'(chip_sel),    int'(e.cs));
            cmp(e.tag, "pad_oe",      int'(pad_oe),      int'(e.oe));
            cmp(e.tag, "pad_dout",    int'(pad_dout),    int'(e.dout));
            cmp(e.tag, "core_rdata",  int'(core_rdata),  int'(e.rdata));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : driver
        // R8: reset state even with a read request present
        apply(0, 16'h0000, 1, 0, 1, 8'h00, 8'h77, "R8 reset");
        apply(0, 16'h0000, 0, 0, 0, 8'h00, 8'h00, "R8 reset idle");
        // R2 R7: qualified read of boot page, transparent
        apply(1, 16'h0010, 1, 0, 1, 8'h00, 8'h5A, "R2 R7 boot read");
        // R7: hold after read with pad changed
        apply(1, 16'h0010, 0, 0, 0, 8'h00, 8'h11, "R7 hold idle");
        // R1: high page decode without request
        apply(1, 16'hFE12, 0, 0, 0, 8'h00, 8'h22, "R1 page FE");
        apply(1, 16'hFF80, 1, 0, 0, 8'h00, 8'h33, "R1 page FF");
        apply(1, 16'hFD00, 0, 0, 0, 8'h00, 8'h44, "R1 page FD");
        apply(1, 16'h0100, 0, 0, 0, 8'h00, 8'h44, "R2 page 01");
        // R5: request with no strobes still selects
        apply(1, 16'h4000, 0, 0, 1, 8'h99, 8'h66, "R5 req no strobe");
        // R3: zero write keeps overlay
        apply(1, 16'hFF50, 0, 1, 1, 8'h00, 8'h00, "R3 zero write");
        apply(1, 16'h0000, 0, 0, 0, 8'h00, 8'h00, "R3 probe after zero");
        // R4: write without request
        apply(1, 16'hFF50, 0, 1, 0, 8'h01, 8'h00, "R4 no req write");
        apply(1, 16'h0000, 0, 0, 0, 8'h00, 8'h00, "R4 probe after noreq");
        // R9 R4: clash cycle, no drive, no latch, no overlay change
        apply(1, 16'hFF50, 1, 1, 1, 8'h01, 8'hC7, "R9 clash");
        apply(1, 16'h0000, 0, 0, 0, 8'h00, 8'h00, "R4 R9 probe after clash");
        // R6 R3: qualified non-zero write unmaps overlay
        apply(1, 16'hFF50, 0, 1, 1, 8'h01, 8'h00, "R6 R3 unmap write");
        apply(1, 16'h0000, 0, 0, 0, 8'h00, 8'h00, "R3 probe after unmap");
        apply(1, 16'hC000, 0, 1, 1, 8'hA5, 8'h00, "R6 write drive");
        apply(1, 16'hFF50, 0, 1, 1, 8'h00, 8'h00, "R3 sticky zero write");
        apply(1, 16'h00FF, 0, 0, 1, 8'h00, 8'h00, "R3 sticky probe");
        // R7: read with pad changing mid-read
        apply(1, 16'h8000, 1, 0, 1, 8'h00, 8'h3C, "R7 read a");
        apply(1, 16'h8001, 1, 0, 1, 8'h00, 8'hC3, "R7 read b");
        apply(1, 16'h8001, 0, 0, 0, 8'h00, 8'h0F, "R7 hold after b");
        // R8: reset remaps overlay and clears hold
        apply(0, 16'h0000, 0, 0, 0, 8'h00, 8'h00, "R8 second reset");
        apply(1, 16'h0000, 0, 0, 0, 8'h00, 8'h00, "R8 after release");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule